// File: doc/BRIEF.md
# Byte-Addressed Data Space Decoder

This block sits between a 16-bit core's data address paths and its data storage. Every address it receives is a 16-bit byte address. It routes each access to one of four regions: a window of special-function registers, a word-wide RAM held inside the block, a hole with no storage, or a program-space visibility window in the upper half of the address range. The register window and the visibility window are served by logic outside the block, through strobe-and-data ports.

A read port and a write port work independently, so one read and one write can be issued in the same cycle. Each port handles either a whole 16-bit word or a single byte. The low byte of a word sits at its even address and the high byte at its odd address. Byte reads come back zero-extended, and byte writes change only the lane they address.

Read results appear one cycle after the request. A small response state machine selects the source for that cycle. It registers one of six states, RS_IDLE, RS_RAM, RS_SFR, RS_PSV, RS_HOLE and RS_FAULT, chosen from the request of the previous cycle:
- No read leads to RS_IDLE.
- A word read at an odd address leads to RS_FAULT.
- Any other read leads to the state of the region that the address decodes to.

Every state can move to every other state on any cycle.

Top module: `ds_space_decoder`

## Requirements
- R1: Address bit 15 set selects the visibility window. With bit 15 clear, 0x0000–0x07FF selects the register window, 0x0800–0x27FF selects RAM and 0x2800–0x7FFF selects the hole. At most one external read strobe is active in a cycle.
- R2: `rd_valid` is high in the cycle after each cycle with `rd_en` high, and low otherwise.
- R3: A word access (`*_byte` = 0) at an even address transfers all 16 bits. Bits 7:0 belong to the even byte address.
- R4: A byte write (`wr_byte` = 1) stores `wr_data[7:0]` into lane `wr_addr[0]` (0 = bits 7:0, 1 = bits 15:8). The other lane keeps its value.
- R5: A byte read returns lane `rd_addr[0]` in bits 7:0, with bits 15:8 set to zero.
- R6: A read in the hole returns zero. A write in the hole raises no strobe and changes no storage.
- R7: A word access at an odd address is refused. A refused read raises no strobe and gives zero data, with `rd_err` high in the response cycle. A refused write changes nothing and raises `wr_err` in the next cycle.
- R8: A write with address bit 15 set is discarded and raises `wr_err` in the next cycle.
- R9: When a read and a write address the same word in the same cycle, the read returns the data held before that write.
- R10: Register-window accesses drive the word address (`addr[10:1]`) and byte enables on the window port, plus lane-steered write data for writes. The read data from that port is taken one cycle after the read strobe. Visibility reads work the same way, with word address `addr[14:1]`.
- R11: After reset, `rd_valid`, `rd_err` and `wr_err` are low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | 16 | Read byte address |
| rd_byte | input | 1 | 1 = byte read, 0 = word read |
| rd_valid | output | 1 | Read response cycle |
| rd_data | output | 16 | Read result |
| rd_err | output | 1 | Refused (misaligned) read |
| wr_en | input | 1 | Write request |
| wr_addr | input | 16 | Write byte address |
| wr_byte | input | 1 | 1 = byte write, 0 = word write |
| wr_data | input | 16 | Write data (byte in bits 7:0) |
| wr_err | output | 1 | Refused write, one cycle later |
| sfr_rd_stb | output | 1 | Register window read strobe |
| sfr_rd_addr | output | 10 | Register window read word address |
| sfr_rd_be | output | 2 | Register window read byte enables |
| sfr_rd_data | input | 16 | Register window read data, one cycle after strobe |
| sfr_wr_stb | output | 1 | Register window write strobe |
| sfr_wr_addr | output | 10 | Register window write word address |
| sfr_wr_be | output | 2 | Register window write byte enables |
| sfr_wr_data | output | 16 | Register window write data |
| psv_rd_stb | output | 1 | Visibility window read strobe |
| psv_rd_addr | output | 14 | Visibility window read word address |
| psv_rd_be | output | 2 | Visibility window read byte enables |
| psv_rd_data | input | 16 | Visibility window read data, one cycle after strobe |

## Verification
If the response state machine latches the wrong source, the fault shows in the very next cycle. The read data comes from the wrong region, or a zero appears where real data was due. A lane register that drifts from the request shows up as the wrong byte, or as nonzero upper bits on a byte read. Steering or index faults in the write path stay hidden until that word is read back. For that reason the bench first fills every backed word, then mixes random reads and writes across all regions and compares each response with a byte-accurate reference model.

// File: rtl/ds_pkg.sv
package ds_pkg;

    // Region selected by a byte address
    typedef enum logic [1:0] {
        RG_SFR  = 2'd0,
        RG_RAM  = 2'd1,
        RG_HOLE = 2'd2,
        RG_PSV  = 2'd3
    } region_e;

    // Source of the read response in the following cycle
    typedef enum logic [2:0] {
        RS_IDLE  = 3'd0,
        RS_RAM   = 3'd1,
        RS_SFR   = 3'd2,
        RS_PSV   = 3'd3,
        RS_HOLE  = 3'd4,
        RS_FAULT = 3'd5
    } rsp_state_e;

endpackage

// File: rtl/ds_region_decode.sv
module ds_region_decode
    import ds_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned LB        = 1,
    parameter int unsigned SFR_LIMIT = 32'h0800,
    parameter int unsigned RAM_LIMIT = 32'h2800
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_acc,
    output region_e           region,
    output logic              misaligned
);
    localparam logic [ADDR_W-1:0] SFR_LIM_A = ADDR_W'(SFR_LIMIT);
    localparam logic [ADDR_W-1:0] RAM_LIM_A = ADDR_W'(RAM_LIMIT);

    always_comb begin
        if (addr[ADDR_W-1])          region = RG_PSV;
        else if (addr < SFR_LIM_A)   region = RG_SFR;
        else if (addr < RAM_LIM_A)   region = RG_RAM;
        else                         region = RG_HOLE;
    end

    // Words need the lane bits clear; bytes may sit anywhere
    assign misaligned = !byte_acc && (addr[LB-1:0] != '0);

endmodule

// File: rtl/ds_lane_steer.sv
module ds_lane_steer #(
    parameter int unsigned LANES = 2,
    parameter int unsigned LB    = 1
) (
    input  logic             byte_acc,
    input  logic [LB-1:0]    lane,
    output logic [LANES-1:0] be
);
    always_comb begin
        if (byte_acc) be = LANES'(1) << lane;
        else          be = '1;
    end
endmodule

// File: rtl/ds_word_ram.sv
module ds_word_ram #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 4096,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned IW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [IW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_q,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [LANES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_d
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Nonblocking read and write at the same edge: the read sees old data
    always_ff @(posedge clk) begin
        if (rd_en) rd_q <= mem[rd_idx];
        if (wr_en) begin
            for (int l = 0; l < int'(LANES); l++) begin
                if (wr_be[l]) mem[wr_idx][l*8 +: 8] <= wr_d[l*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/ds_space_decoder.sv
module ds_space_decoder
    import ds_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SFR_LIMIT = 32'h0800,
    parameter int unsigned RAM_LIMIT = 32'h2800,
    localparam int unsigned LANES     = DATA_W / 8,
    localparam int unsigned LB        = $clog2(LANES),
    localparam int unsigned SFR_AW    = $clog2(SFR_LIMIT / LANES),
    localparam int unsigned PSV_AW    = ADDR_W - 1 - LB,
    localparam int unsigned RAM_WORDS = (RAM_LIMIT - SFR_LIMIT) / LANES,
    localparam int unsigned RAM_IW    = $clog2(RAM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_byte,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_byte,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_err,
    output logic              sfr_rd_stb,
    output logic [SFR_AW-1:0] sfr_rd_addr,
    output logic [LANES-1:0]  sfr_rd_be,
    input  logic [DATA_W-1:0] sfr_rd_data,
    output logic              sfr_wr_stb,
    output logic [SFR_AW-1:0] sfr_wr_addr,
    output logic [LANES-1:0]  sfr_wr_be,
    output logic [DATA_W-1:0] sfr_wr_data,
    output logic              psv_rd_stb,
    output logic [PSV_AW-1:0] psv_rd_addr,
    output logic [LANES-1:0]  psv_rd_be,
    input  logic [DATA_W-1:0] psv_rd_data
);
    localparam logic [ADDR_W-1:0] RAM_BASE = ADDR_W'(SFR_LIMIT);

    // ---------------- address classification ----------------
    region_e rd_region, wr_region;
    logic    rd_mis, wr_mis;

    ds_region_decode #(
        .ADDR_W(ADDR_W), .LB(LB), .SFR_LIMIT(SFR_LIMIT), .RAM_LIMIT(RAM_LIMIT)
    ) u_rd_dec (
        .addr(rd_addr), .byte_acc(rd_byte), .region(rd_region), .misaligned(rd_mis)
    );

    ds_region_decode #(
        .ADDR_W(ADDR_W), .LB(LB), .SFR_LIMIT(SFR_LIMIT), .RAM_LIMIT(RAM_LIMIT)
    ) u_wr_dec (
        .addr(wr_addr), .byte_acc(wr_byte), .region(wr_region), .misaligned(wr_mis)
    );

    // ---------------- byte enables per port ----------------
    logic [LANES-1:0] rd_be, wr_be;

    ds_lane_steer #(.LANES(LANES), .LB(LB)) u_rd_steer (
        .byte_acc(rd_byte), .lane(rd_addr[LB-1:0]), .be(rd_be)
    );

    ds_lane_steer #(.LANES(LANES), .LB(LB)) u_wr_steer (
        .byte_acc(wr_byte), .lane(wr_addr[LB-1:0]), .be(wr_be)
    );

    // A byte write carries its value in the low lane; copy it to every lane
    logic [DATA_W-1:0] wr_lanes;
    assign wr_lanes = wr_byte ? {LANES{wr_data[7:0]}} : wr_data;

    // ---------------- request qualification ----------------
    logic rd_go, wr_go;
    assign rd_go = rd_en && !rd_mis;
    assign wr_go = wr_en && !wr_mis;

    logic ram_rd, ram_wr;
    assign ram_rd     = rd_go && (rd_region == RG_RAM);
    assign ram_wr     = wr_go && (wr_region == RG_RAM);
    assign sfr_rd_stb = rd_go && (rd_region == RG_SFR);
    assign sfr_wr_stb = wr_go && (wr_region == RG_SFR);
    assign psv_rd_stb = rd_go && (rd_region == RG_PSV);

    assign sfr_rd_addr = SFR_AW'(rd_addr >> LB);
    assign sfr_wr_addr = SFR_AW'(wr_addr >> LB);
    assign psv_rd_addr = PSV_AW'(rd_addr >> LB);
    assign sfr_rd_be   = rd_be;
    assign psv_rd_be   = rd_be;
    assign sfr_wr_be   = wr_be;
    assign sfr_wr_data = wr_lanes;

    // ---------------- behavioural RAM ----------------
    logic [RAM_IW-1:0] ram_rd_idx, ram_wr_idx;
    logic [DATA_W-1:0] ram_q;

    assign ram_rd_idx = RAM_IW'((rd_addr - RAM_BASE) >> LB);
    assign ram_wr_idx = RAM_IW'((wr_addr - RAM_BASE) >> LB);

    ds_word_ram #(.DATA_W(DATA_W), .DEPTH(RAM_WORDS)) u_ram (
        .clk(clk),
        .rd_en(ram_rd), .rd_idx(ram_rd_idx), .rd_q(ram_q),
        .wr_en(ram_wr), .wr_idx(ram_wr_idx), .wr_be(wr_be), .wr_d(wr_lanes)
    );

    // ---------------- read response state machine ----------------
    rsp_state_e rsp_q, rsp_d;
    logic       byte_q;
    logic [LB-1:0] lane_q;

    always_comb begin
        if (!rd_en) begin
            rsp_d = RS_IDLE;
        end else if (rd_mis) begin
            rsp_d = RS_FAULT;
        end else begin
            unique case (rd_region)
                RG_SFR:  rsp_d = RS_SFR;
                RG_RAM:  rsp_d = RS_RAM;
                RG_HOLE: rsp_d = RS_HOLE;
                RG_PSV:  rsp_d = RS_PSV;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q  <= RS_IDLE;
            byte_q <= 1'b0;
            lane_q <= '0;
        end else begin
            rsp_q  <= rsp_d;
            byte_q <= rd_byte;
            lane_q <= rd_addr[LB-1:0];
        end
    end

    // Output process: pick the source word, then narrow it for byte reads
    logic [DATA_W-1:0] src_word;

    always_comb begin
        src_word = '0;
        rd_valid = 1'b1;
        rd_err   = 1'b0;
        unique case (rsp_q)
            RS_IDLE:  rd_valid = 1'b0;
            RS_RAM:   src_word = ram_q;
            RS_SFR:   src_word = sfr_rd_data;
            RS_PSV:   src_word = psv_rd_data;
            RS_HOLE:  src_word = '0;
            RS_FAULT: rd_err   = 1'b1;
            default:  rd_valid = 1'b0;
        endcase
        if (byte_q) rd_data = {{(DATA_W-8){1'b0}}, src_word[{lane_q, 3'b000} +: 8]};
        else        rd_data = src_word;
    end

    // ---------------- write refusal flag ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= wr_en && (wr_mis || wr_region == RG_PSV);
    end

endmodule

// File: rtl/ds_space_checker.sv
module ds_space_checker #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned HOLE_START = 32'h2800
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_byte,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_err,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_err,
    input logic              sfr_rd_stb,
    input logic              psv_rd_stb
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r2_quiet_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    a_r1_one_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sfr_rd_stb, psv_rd_stb}));

    a_r5_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_en && rd_byte)) |-> rd_data[DATA_W-1:8] == '0);

    a_r6_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_addr[ADDR_W-1] && rd_addr >= ADDR_W'(HOLE_START)) |=> rd_data == '0);

    a_r7_misaligned_read_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_byte && rd_addr[0]) |=> (rd_err && rd_data == '0));

    a_r7_misaligned_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_byte && rd_addr[0]) |-> !(sfr_rd_stb || psv_rd_stb));

    a_r8_psv_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[ADDR_W-1]) |=> wr_err);

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0 && !rd_err));
endmodule

bind ds_space_decoder ds_space_checker u_ds_space_checker (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_byte(rd_byte),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_err(wr_err),
    .sfr_rd_stb(sfr_rd_stb), .psv_rd_stb(psv_rd_stb)
);

// File: tb/test_ds_space_decoder.sv
`timescale 1ns/1ps
module test_ds_space_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, rd_byte = 1'b0, wr_en = 1'b0, wr_byte = 1'b0;
    logic [15:0] rd_addr = '0, wr_addr = '0, wr_data = '0;
    logic        rd_valid, rd_err, wr_err;
    logic [15:0] rd_data;
    logic        sfr_rd_stb, sfr_wr_stb, psv_rd_stb;
    logic [9:0]  sfr_rd_addr, sfr_wr_addr;
    logic [1:0]  sfr_rd_be, sfr_wr_be, psv_rd_be;
    logic [15:0] sfr_wr_data;
    logic [15:0] sfr_rd_data = '0, psv_rd_data = '0;
    logic [13:0] psv_rd_addr;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ds_space_decoder i_ds_space_decoder (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_byte(rd_byte),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte), .wr_data(wr_data),
        .wr_err(wr_err),
        .sfr_rd_stb(sfr_rd_stb), .sfr_rd_addr(sfr_rd_addr), .sfr_rd_be(sfr_rd_be),
        .sfr_rd_data(sfr_rd_data),
        .sfr_wr_stb(sfr_wr_stb), .sfr_wr_addr(sfr_wr_addr), .sfr_wr_be(sfr_wr_be),
        .sfr_wr_data(sfr_wr_data),
        .psv_rd_stb(psv_rd_stb), .psv_rd_addr(psv_rd_addr), .psv_rd_be(psv_rd_be),
        .psv_rd_data(psv_rd_data)
    );

    // External register window model and visibility window model
    logic [15:0] sfr_mem [1024];

    function automatic logic [15:0] psv_fn(input logic [13:0] wa);
        return {wa[7:0] ^ 8'h5A, wa[13:6] ^ 8'hC3};
    endfunction

    always @(posedge clk) begin
        if (sfr_rd_stb) sfr_rd_data <= sfr_mem[sfr_rd_addr];
        if (psv_rd_stb) psv_rd_data <= psv_fn(psv_rd_addr);
        if (sfr_wr_stb) begin
            if (sfr_wr_be[0]) sfr_mem[sfr_wr_addr][7:0]  <= sfr_wr_data[7:0];
            if (sfr_wr_be[1]) sfr_mem[sfr_wr_addr][15:8] <= sfr_wr_data[15:8];
        end
    end

    // Reference model of every backed word (register window plus RAM)
    logic [15:0] ref_mem [5120];

    function automatic int region_of(input logic [15:0] a);
        if (a[15])            return 3;
        else if (a < 16'h0800) return 0;
        else if (a < 16'h2800) return 1;
        else                  return 2;
    endfunction

    function automatic logic [15:0] exp_read(input logic [15:0] a, input logic b);
        logic [15:0] w;
        if (!b && a[0]) return 16'h0000;
        case (region_of(a))
            3:       w = psv_fn(a[14:1]);
            2:       w = 16'h0000;
            default: w = ref_mem[a[15:1]];
        endcase
        if (b) return {8'h00, a[0] ? w[15:8] : w[7:0]};
        return w;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, check strobes, check responses at the next falling edge
    task automatic op(input logic re, input logic [15:0] ra, input logic rb,
                      input logic we, input logic [15:0] wa, input logic wb,
                      input logic [15:0] wd, input string rtag);
        logic [15:0] e_rd;
        logic        e_rerr, e_werr, e_sfr_wr, e_sfr_rd, e_psv_rd;
        string       tag;
        e_rd     = re ? exp_read(ra, rb) : 16'h0000;
        e_rerr   = re && !rb && ra[0];
        e_werr   = we && ((!wb && wa[0]) || wa[15]);
        e_sfr_wr = we && !(!wb && wa[0]) && region_of(wa) == 0;
        e_sfr_rd = re && !(!rb && ra[0]) && region_of(ra) == 0;
        e_psv_rd = re && !(!rb && ra[0]) && region_of(ra) == 3;
        if (we && !(!wb && wa[0]) && region_of(wa) <= 1) begin
            if (!wb)        ref_mem[wa[15:1]]        = wd;
            else if (wa[0]) ref_mem[wa[15:1]][15:8]  = wd[7:0];
            else            ref_mem[wa[15:1]][7:0]   = wd[7:0];
        end
        rd_en = re; rd_addr = ra; rd_byte = rb;
        wr_en = we; wr_addr = wa; wr_byte = wb; wr_data = wd;
        #1;
        check("R10 sfr_wr_stb", {15'h0, sfr_wr_stb}, {15'h0, e_sfr_wr});
        check("R1 sfr_rd_stb", {15'h0, sfr_rd_stb}, {15'h0, e_sfr_rd});
        check("R1 psv_rd_stb", {15'h0, psv_rd_stb}, {15'h0, e_psv_rd});
        if (e_sfr_wr) begin
            check("R10 sfr_wr_addr", {6'h0, sfr_wr_addr}, {6'h0, wa[10:1]});
            check("R10 sfr_wr_be", {14'h0, sfr_wr_be}, wb ? (wa[0] ? 16'h2 : 16'h1) : 16'h3);
        end
        if (e_psv_rd) check("R10 psv_rd_addr", {2'h0, psv_rd_addr}, {2'h0, ra[14:1]});
        @(negedge clk);
        if (rtag != "")                tag = rtag;
        else if (e_rerr)               tag = "R7";
        else if (region_of(ra) == 2)   tag = "R6";
        else if (rb)                   tag = "R5";
        else                           tag = "R3";
        check("R2 rd_valid", {15'h0, rd_valid}, {15'h0, re});
        check({tag, " rd_data"}, rd_data, e_rd);
        check("R7 rd_err", {15'h0, rd_err}, {15'h0, e_rerr});
        check(wa[15] ? "R8 wr_err" : "R7 wr_err", {15'h0, wr_err}, {15'h0, e_werr});
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    function automatic logic [15:0] rand_addr();
        logic [15:0] a;
        case ($urandom % 6)
            0:       a = 16'($urandom % 16'h0800);
            1, 2:    a = 16'h0800 + 16'($urandom % 16'h2000);
            3:       a = 16'h2800 + 16'($urandom % 16'h5800);
            default: a = 16'h8000 | 16'($urandom);
        endcase
        return a;
    endfunction

    initial begin : watchdog
        #(5ns * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R11: state after reset
        check("R11 rd_valid", {15'h0, rd_valid}, 16'h0);
        check("R11 rd_data", rd_data, 16'h0);
        check("R11 rd_err", {15'h0, rd_err}, 16'h0);
        check("R11 wr_err", {15'h0, wr_err}, 16'h0);

        // Fill every backed word with word writes (R3)
        for (int i = 0; i < 5120; i++)
            op(1'b0, 16'h0, 1'b0, 1'b1, 16'(i * 2), 1'b0, 16'(i * 32'h9E37) ^ 16'h1234, "");

        // R1 boundaries
        op(1'b1, 16'h07FE, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R1");
        op(1'b1, 16'h0800, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R1");
        op(1'b1, 16'h27FE, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R1");
        op(1'b1, 16'h2800, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R1");
        op(1'b1, 16'h7FFE, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R1");
        op(1'b1, 16'h8000, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R1");
        op(1'b1, 16'hFFFF, 1'b1, 1'b0, 16'h0, 1'b0, 16'h0, "R1");

        // R4: byte writes to each lane in RAM and in the register window, then read back
        op(1'b0, 16'h0, 1'b0, 1'b1, 16'h1001, 1'b1, 16'hFFA5, "");
        op(1'b1, 16'h1000, 1'b0, 1'b1, 16'h1000, 1'b1, 16'h003C, "R4");
        op(1'b1, 16'h1000, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R4");
        op(1'b0, 16'h0, 1'b0, 1'b1, 16'h0123, 1'b1, 16'h77AB, "");
        op(1'b1, 16'h0122, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R4");
        op(1'b1, 16'h0123, 1'b1, 1'b0, 16'h0, 1'b0, 16'h0, "R5");

        // R9: read and write to one word in the same cycle
        op(1'b1, 16'h2000, 1'b0, 1'b1, 16'h2000, 1'b0, 16'hBEEF, "R9");
        op(1'b1, 16'h2000, 1'b0, 1'b1, 16'h2001, 1'b1, 16'h0011, "R9");
        op(1'b1, 16'h2000, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R9");
        op(1'b1, 16'h0200, 1'b0, 1'b1, 16'h0200, 1'b0, 16'h5A5A, "R9");
        op(1'b1, 16'h0200, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R9");

        // R6: hole write then read; R7: misaligned word; R8: visibility write
        op(1'b0, 16'h0, 1'b0, 1'b1, 16'h3000, 1'b0, 16'hFFFF, "");
        op(1'b1, 16'h3000, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R6");
        op(1'b1, 16'h0901, 1'b0, 1'b1, 16'h0901, 1'b0, 16'hDEAD, "R7");
        op(1'b1, 16'h0900, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R7");
        op(1'b0, 16'h0, 1'b0, 1'b1, 16'h9000, 1'b0, 16'h1111, "");
        op(1'b1, 16'h0901, 1'b1, 1'b0, 16'h0, 1'b0, 16'h0, "R5");

        // Random mix across all regions
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] ra, wa;
            ra = rand_addr();
            wa = ($urandom % 8 == 0) ? ra : rand_addr();
            op(1'($urandom), ra, 1'($urandom), 1'($urandom), wa, 1'($urandom),
               16'($urandom), "");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule